// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

This block is the front end of a small byte-oriented processor. Program memory is read one byte per clock cycle, with the read data returned in the same cycle as the address. The first byte of every instruction carries the whole opcode, and the unit works out from that byte alone how many further bytes belong to the instruction. It collects those bytes, least significant first, into an operand register as wide as the program counter. When the last byte has arrived, it presents the opcode and the zero-extended operand together for exactly one cycle.

Control transfers are resolved downstream. The execute stage can force a new fetch address at any time. That request wins over everything else: any instruction that is partly gathered, or is about to be issued, is dropped, and fetching resumes at the new address.

Top module: `fetch_unit`

## Requirements
- R1: While reset is applied, `instr_valid` and `mem_rd` are low and `mem_addr` equals `RESET_PC` (default 0). The first opcode fetch after reset is taken from `RESET_PC`.
- R2: Instruction length comes from the opcode byte only. Opcodes 8'h00 (no-op) and 8'h01 (return) are one byte long. Opcodes 8'h10 through 8'h1F (byte immediate) are two bytes long. Opcodes 8'h20, 8'h21 and 8'h22 (jump, jump-if-zero, jump-if-nonzero) are one byte followed by PC_W/8 address bytes.
- R3: Each fetch cycle reads the byte at `mem_addr` with `mem_rd` high, and `mem_addr` then advances by one, wrapping modulo 2^PC_W. When no byte is fetched, `mem_addr` holds its value.
- R4: `instr_valid` is high for one cycle only, in the cycle after the last byte of an instruction is fetched. `mem_rd` is low in that cycle, and the next opcode is fetched in the following cycle. An n-byte instruction therefore issues n+1 cycles after the previous issue or address load.
- R5: `instr_operand` holds the operand bytes with the first fetched byte in bits 7:0, and every bit above the fetched bytes is zero. This includes bits left over from an earlier, longer instruction. One-byte instructions issue with an operand of zero.
- R6: An opcode outside the set listed in R2 is treated as one byte long and issues with `instr_illegal` high. `instr_illegal` is never high outside an issue cycle, and it is low for every listed opcode.
- R7: A cycle with `pc_load` high fetches nothing and issues nothing, whatever the state. The next cycle fetches an opcode from `pc_load_addr`, and any partly gathered instruction is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mem_addr | output | PC_W | Byte address for program memory (the fetch program counter) |
| mem_rd | output | 1 | High in cycles that consume `mem_rdata` |
| mem_rdata | input | 8 | Byte read from `mem_addr`, valid in the same cycle |
| pc_load | input | 1 | Request from the execute stage to redirect fetch |
| pc_load_addr | input | PC_W | New fetch address, used when `pc_load` is high |
| instr_valid | output | 1 | One-cycle pulse marking a complete instruction |
| instr_opcode | output | 8 | Opcode byte of the issued instruction |
| instr_operand | output | PC_W | Zero-extended operand, first fetched byte in the low byte |
| instr_illegal | output | 1 | High with `instr_valid` when the opcode is not in the length table |

## Verification
The bench builds the block with PC_W at its default of 16 and RESET_PC at 0, so a jump carries two address bytes. Two- and three-byte gathering therefore both occur, and bytes can be left in the upper lane from a jump just before a one-byte immediate. With a 16-bit counter, a jump placed at 16'hFFFE makes its last byte wrap to address 0. The bench also redirects fetch while an operand is being gathered and in the cycle an instruction would issue, and checks that nothing from the abandoned instruction appears.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    ST_OPCODE  = 2'd0,
    ST_OPERAND = 2'd1,
    ST_ISSUE   = 2'd2
  } fetch_state_e;

  // Opcode classes used by the length decode
  localparam byte_t OP_NOP      = 8'h00;
  localparam byte_t OP_RET      = 8'h01;
  localparam byte_t OP_IMM_BASE = 8'h10;  // 8'h10..8'h1F carry one byte
  localparam byte_t OP_JMP      = 8'h20;
  localparam byte_t OP_JZ       = 8'h21;
  localparam byte_t OP_JNZ      = 8'h22;

endpackage

// File: rtl/fetch_rst_sync.sv
module fetch_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/fetch_len_decode.sv
module fetch_len_decode
  import fetch_pkg::*;
#(
  parameter int PC_BYTES = 2,
  parameter int CNT_W    = 2
) (
  input  byte_t            opcode,
  output logic [CNT_W-1:0] extra_bytes,
  output logic             illegal
);

  always_comb begin
    extra_bytes = '0;
    illegal     = 1'b0;
    if ((opcode == OP_NOP) || (opcode == OP_RET)) begin
      extra_bytes = '0;
    end else if (opcode[7:4] == OP_IMM_BASE[7:4]) begin
      extra_bytes = CNT_W'(1);
    end else if ((opcode == OP_JMP) || (opcode == OP_JZ) || (opcode == OP_JNZ)) begin
      extra_bytes = CNT_W'(PC_BYTES);
    end else begin
      illegal = 1'b1;
    end
  end

endmodule

// File: rtl/fetch_pc.sv
module fetch_pc #(
  parameter int          PC_W     = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PC_W-1:0] load_addr,
  input  logic            step,
  output logic [PC_W-1:0] pc
);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic            pc_en;

  assign pc_en = load | step;
  assign pc_d  = load ? load_addr : (pc_q + PC_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign pc = pc_q;

endmodule

// File: rtl/fetch_operand_asm.sv
module fetch_operand_asm
  import fetch_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            capture,
  input  byte_t           data,
  output logic [PC_W-1:0] operand
);

  localparam int LANES = PC_W / BYTE_W;
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (clear) begin
      idx_q <= '0;
    end else if (capture) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    byte_t lane_q;
    logic  lane_hit;

    assign lane_hit = capture && (idx_q == IDX_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (clear) begin
        lane_q <= '0;
      end else if (lane_hit) begin
        lane_q <= data;
      end
    end

    assign operand[b*BYTE_W +: BYTE_W] = lane_q;
  end

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
  import fetch_pkg::*;
#(
  parameter int              PC_W     = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PC_W-1:0] mem_addr,
  output logic            mem_rd,
  input  logic [7:0]      mem_rdata,
  input  logic            pc_load,
  input  logic [PC_W-1:0] pc_load_addr,
  output logic            instr_valid,
  output logic [7:0]      instr_opcode,
  output logic [PC_W-1:0] instr_operand,
  output logic            instr_illegal
);

  localparam int PC_BYTES = PC_W / BYTE_W;
  localparam int CNT_W    = $clog2(PC_BYTES + 1);

  logic             rst_q_n;
  fetch_state_e     state_q, state_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  byte_t            opcode_q;
  logic             illegal_q;
  logic [CNT_W-1:0] dec_extra;
  logic             dec_illegal;
  logic             fetch_en;
  logic             take_opcode;
  logic             take_operand;

  fetch_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  fetch_len_decode #(
    .PC_BYTES (PC_BYTES),
    .CNT_W    (CNT_W)
  ) u_len_dec (
    .opcode      (mem_rdata),
    .extra_bytes (dec_extra),
    .illegal     (dec_illegal)
  );

  // A byte is consumed in every gathering state unless a redirect wins
  assign fetch_en     = rst_q_n && (state_q != ST_ISSUE) && !pc_load;
  assign take_opcode  = fetch_en && (state_q == ST_OPCODE);
  assign take_operand = fetch_en && (state_q == ST_OPERAND);

  fetch_pc #(
    .PC_W     (PC_W),
    .RESET_PC (RESET_PC)
  ) u_pc (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .load      (pc_load),
    .load_addr (pc_load_addr),
    .step      (fetch_en),
    .pc        (mem_addr)
  );

  fetch_operand_asm #(
    .PC_W (PC_W)
  ) u_opnd (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .clear   (take_opcode),
    .capture (take_operand),
    .data    (mem_rdata),
    .operand (instr_operand)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    if (pc_load) begin
      state_d = ST_OPCODE;
    end else begin
      unique case (state_q)
        ST_OPCODE: begin
          if (dec_extra == '0) begin
            state_d = ST_ISSUE;
          end else begin
            state_d  = ST_OPERAND;
            remain_d = dec_extra;
          end
        end
        ST_OPERAND: begin
          remain_d = remain_q - CNT_W'(1);
          if (remain_q == CNT_W'(1)) begin
            state_d = ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          state_d = ST_OPCODE;
        end
        default: begin
          state_d = ST_OPCODE;
        end
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q  <= ST_OPCODE;
      remain_q <= '0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
    end
  end

  // Opcode holding register, enabled on the opcode byte
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      opcode_q  <= '0;
      illegal_q <= 1'b0;
    end else if (take_opcode) begin
      opcode_q  <= mem_rdata;
      illegal_q <= dec_illegal;
    end
  end

  assign mem_rd        = fetch_en;
  assign instr_valid   = (state_q == ST_ISSUE) && !pc_load;
  assign instr_opcode  = opcode_q;
  assign instr_illegal = instr_valid && illegal_q;

endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk
  import fetch_pkg::*;
#(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] mem_addr,
  input logic            mem_rd,
  input logic            pc_load,
  input logic [PC_W-1:0] pc_load_addr,
  input logic            instr_valid,
  input logic [7:0]      instr_opcode,
  input logic [PC_W-1:0] instr_operand,
  input logic            instr_illegal
);

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> !instr_valid);

  assert_valid_after_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> (!mem_rd && $past(mem_rd)));

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (mem_addr == $past(mem_addr) + PC_W'(1)));

  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd && !pc_load) |=> $stable(mem_addr));

  assert_load_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (!instr_valid && !mem_rd));

  assert_load_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> ((mem_addr == $past(pc_load_addr)) && (pc_load || mem_rd)));

  assert_illegal_qual_R6: assert property (@(posedge clk) disable iff (!rst_n)
    instr_illegal |-> instr_valid);

  assert_short_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && ((instr_opcode == OP_NOP) || (instr_opcode == OP_RET)))
      |-> (instr_operand == '0));

endmodule

bind fetch_unit fetch_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_q_n),
  .mem_addr      (mem_addr),
  .mem_rd        (mem_rd),
  .pc_load       (pc_load),
  .pc_load_addr  (pc_load_addr),
  .instr_valid   (instr_valid),
  .instr_opcode  (instr_opcode),
  .instr_operand (instr_operand),
  .instr_illegal (instr_illegal)
);

// File: tb/tb_fetch_unit.sv
`timescale 1ns/1ps
module tb_fetch_unit;

  localparam int PC_W = 16;

  typedef struct {
    logic [7:0]  opcode;
    logic [15:0] operand;
    logic        illegal;
    int          len;
    logic [15:0] next_pc;
  } exp_t;

  logic            clk;
  logic            rst_n;
  logic [PC_W-1:0] mem_addr;
  logic            mem_rd;
  logic [7:0]      mem_rdata;
  logic            pc_load;
  logic [PC_W-1:0] pc_load_addr;
  logic            instr_valid;
  logic [7:0]      instr_opcode;
  logic [PC_W-1:0] instr_operand;
  logic            instr_illegal;

  logic [7:0] mem [0:255];
  exp_t exp_q[$];
  exp_t stage_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   cyc      = 0;
  int   last_evt = 0;
  bit   have_last = 0;
  bit   done = 0;

  fetch_unit #(.PC_W(PC_W), .RESET_PC(16'h0000)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_addr      (mem_addr),
    .mem_rd        (mem_rd),
    .mem_rdata     (mem_rdata),
    .pc_load       (pc_load),
    .pc_load_addr  (pc_load_addr),
    .instr_valid   (instr_valid),
    .instr_opcode  (instr_opcode),
    .instr_operand (instr_operand),
    .instr_illegal (instr_illegal)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Independent model of the length table (R2, R6)
  function automatic int model_len(input logic [7:0] op);
    if (op == 8'h00 || op == 8'h01) return 1;
    if (op[7:4] == 4'h1) return 2;
    if (op >= 8'h20 && op <= 8'h22) return 1 + PC_W / 8;
    return 1;
  endfunction

  function automatic bit model_illegal(input logic [7:0] op);
    return !(op == 8'h00 || op == 8'h01 || op[7:4] == 4'h1 || (op >= 8'h20 && op <= 8'h22));
  endfunction

  // Driver: writes the instruction bytes and stages the expected item
  task automatic put_instr(inout logic [15:0] a, input logic [7:0] op, input logic [15:0] opnd);
    exp_t it;
    int n;
    logic [15:0] t;
    n = model_len(op);
    mem[a[7:0]] = op;
    for (int i = 1; i < n; i++) begin
      t = a + 16'(i);
      mem[t[7:0]] = opnd[(i-1)*8 +: 8];
    end
    it.opcode  = op;
    it.illegal = model_illegal(op);
    it.len     = n;
    it.operand = (n == 1) ? 16'h0000 : (n == 2) ? {8'h00, opnd[7:0]} : opnd;
    a = a + 16'(n);
    it.next_pc = a;
    stage_q.push_back(it);
  endtask

  task automatic do_load(input logic [15:0] addr);
    @(negedge clk);
    pc_load      = 1'b1;
    pc_load_addr = addr;
    while (stage_q.size() > 0) exp_q.push_back(stage_q.pop_front());
    @(negedge clk);
    pc_load = 1'b0;
  endtask

  task automatic wait_drain();
    int guard;
    guard = 0;
    while (exp_q.size() > 0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check(exp_q.size() == 0, "R4 drain", exp_q.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: pops expected items as issues appear
  initial begin
    exp_t it;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (instr_valid && exp_q.size() > 0) begin
          it = exp_q.pop_front();
          check(instr_opcode == it.opcode, "R2 opcode", instr_opcode, it.opcode);
          check(instr_operand == it.operand, "R5 operand", instr_operand, it.operand);
          check(instr_illegal == it.illegal, "R6 illegal flag", instr_illegal, it.illegal);
          check(mem_addr == it.next_pc, "R3 next address", mem_addr, it.next_pc);
          check(mem_rd == 1'b0, "R4 no fetch on issue", mem_rd, 0);
          if (have_last)
            check((cyc - last_evt) == it.len + 1, "R4 issue spacing",
                  cyc - last_evt, it.len + 1);
        end
        if (instr_valid || pc_load) begin
          last_evt  = cyc;
          have_last = 1;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] a;
    rst_n        = 1'b0;
    pc_load      = 1'b0;
    pc_load_addr = '0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;

    // Boot program at the reset address
    a = 16'h0000;
    put_instr(a, 8'h01, 16'h0000);
    put_instr(a, 8'h1F, 16'h005A);

    repeat (3) @(negedge clk);
    check(instr_valid == 1'b0, "R1 valid in reset", instr_valid, 0);
    check(mem_rd == 1'b0, "R1 no read in reset", mem_rd, 0);
    check(mem_addr == 16'h0000, "R1 reset address", mem_addr, 0);
    while (stage_q.size() > 0) exp_q.push_back(stage_q.pop_front());
    rst_n = 1'b1;
    wait_drain();

    // Mixed lengths, table boundaries and lane clearing (R2, R5, R6)
    a = 16'h0040;
    put_instr(a, 8'h00, 16'h0000);
    put_instr(a, 8'h01, 16'h0000);
    put_instr(a, 8'h12, 16'h00AB);
    put_instr(a, 8'h20, 16'h1234);
    put_instr(a, 8'h22, 16'hBEEF);
    put_instr(a, 8'h7F, 16'h0000);
    put_instr(a, 8'h02, 16'h0000);
    put_instr(a, 8'h23, 16'h0000);
    put_instr(a, 8'h0F, 16'h0000);
    put_instr(a, 8'h10, 16'h0000);
    put_instr(a, 8'h20, 16'hFFFF);
    put_instr(a, 8'h1A, 16'h0080);
    put_instr(a, 8'hFF, 16'h0000);
    do_load(16'h0040);
    wait_drain();

    // Address wrap through a three-byte jump (R3); byte at 0 is 8'h01
    a = 16'hFFFE;
    put_instr(a, 8'h21, 16'h01EF);
    do_load(16'hFFFE);
    wait_drain();

    // Redirect while gathering operand bytes (R7)
    a = 16'h0080;
    put_instr(a, 8'h20, 16'h2211);
    stage_q.delete();
    a = 16'h0090;
    do_load(16'h0080);
    put_instr(a, 8'h13, 16'h0077);
    do_load(16'h0090);
    wait_drain();

    // Redirect in the cycle a one-byte instruction would issue (R7)
    a = 16'h00A0;
    put_instr(a, 8'h00, 16'h0000);
    stage_q.delete();
    a = 16'h00B0;
    do_load(16'h00A0);
    put_instr(a, 8'h01, 16'h0000);
    do_load(16'h00B0);
    wait_drain();

    finish_run();
  end

endmodule